// File: doc/BRIEF.md
# Command Queue Launch and Completion Controller

This block sits between software and a command-buffer fetch engine. It serves several independent control paths, each with two submission queues. For each path and queue, software programs a buffer address and a command word, then launches the queue in one of two ways: it writes the shared launch register, or (for queue 1 only) an external flush pulse does it. Before a launch becomes a start request toward the fetch engine, the block checks the engine enable, the per-path reset, the queue's busy state and the descriptor. The address and command are captured when the start is issued.

When the fetch engine reports that a submission has finished, the queue becomes idle again. If that submission carried the last-command flag, a completion bit is raised in a shared status word. The completion bits of the paths and queues sit at fixed, irregular positions. Rejected launches raise error bits. Software clears both the status word and the error word by writing ones. A per-path reset register holds the path in reset for a fixed number of cycles. During that time the path drops its pending submissions and refuses new ones.

Register offsets (byte addresses on a 12-bit bus):
- 0x004: enable.
- 0x014 + 16·p: queue-0 address/command pair. 0x01C + 16·p: queue-1 pair.
- 0x090: completion status. 0x0B0: completion clear.
- 0x0A0: error status. 0x0C0: error clear.
- 0x0D4: launch register.
- 0x0E4 + 4·p: path reset.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset, the following all read 0 and no start or busy output is active: enable, completion status, error status, all descriptor words and all path-reset bits.
- R2: A write to a descriptor word reads back unchanged. The address word of path p, queue q is at 0x014+16p+8q and its command word is 4 bytes higher.
- R3: A start is accepted when five conditions hold: the engine is enabled (0x004 bit0 = 1), the path is not in reset, the queue is idle, the descriptor is valid and a launch is requested. The launch register 0x0D4 requests queue 0 with bit0 and queue 1 with bit4, and bits 10:8 give the path. On acceptance, the queue's start output pulses high for exactly one cycle, in the cycle after the launching write. Its address/command outputs then show the captured descriptor, and its busy output rises.
- R4: A fetch-done pulse on a busy queue makes that queue idle. If the captured command had bit24 (last command) set, the queue's completion bit is set in 0x090. The bit positions for paths 0..5 are: queue 0 at 16,17,18,19,25,26 and queue 1 at 21,22,23,24,27,28. A submission without bit24 completes with no status change.
- R5: Writing ones to 0x0B0 clears the matching bits of 0x090. Other bits are unaffected.
- R6: A launch on a busy queue is ignored: there is no start pulse and the captured descriptor is kept. It sets error bit0 in 0x0A0.
- R7: A descriptor is valid only if all of the following hold:
  - the dword count (bits 13:0) is nonzero;
  - address bits 7:0 are zero;
  - the operation in bits 23:22 is 1 (write), or 2 (read) on queue 0 only.

  A launch with an invalid descriptor is rejected and sets error bit1.
- R8: A launch while the engine is disabled is rejected and sets error bit2.
- R9: A one-cycle pulse on flush input p launches queue 1 of path p, under the same rules as the launch register.
- R10: Writing bit0 of the reset register of path p starts a reset of 4 cycles. While it runs, the bit reads 1, and both queues of the path go idle by the second cycle. Launches during the reset are rejected with error bit16. After the reset ends, the path accepts launches again.
- R11: Writing ones to 0x0C0 clears the matching bits of 0x0A0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 12 | Register read byte address |
| reg_rdata | output | 32 | Register read data (combinational) |
| flush_i | input | NUM_PATHS | Per-path flush pulse launching queue 1 |
| fetch_start_o | output | 2*NUM_PATHS | One-cycle start per queue, index 2p+q |
| fetch_addr_o | output | 64*NUM_PATHS | Captured buffer address per queue |
| fetch_cmd_o | output | 64*NUM_PATHS | Captured command word per queue |
| fetch_done_i | input | 2*NUM_PATHS | Fetch-engine completion pulse per queue |
| fetch_busy_o | output | 2*NUM_PATHS | Queue busy flags |

## Verification
The hardest situation to reach is a reset that lands on a path whose two queues are both busy, with another launch arriving while the reset is still counting. The stimulus first starts queue 0 of path 2 through the launch register and queue 1 through its flush pulse, and leaves both unfinished. It then writes the reset register and sends a launch in the very next cycle. It checks that the busy flags are dropped, that error bit16 is set and that no start pulse appears. It then follows the reset readback cycle by cycle until the path launches again. The sweep also covers the scattered completion bits: every path and queue is driven in turn, with expected bit positions computed in the bench.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned MAX_PATHS  = 6;

    localparam logic [ADDR_W-1:0] OFF_ENABLE  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_DESC    = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 12'h090;
    localparam logic [ADDR_W-1:0] OFF_ERR     = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_ST_CLR  = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFF_ERR_CLR = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFF_LAUNCH  = 12'h0D4;
    localparam logic [ADDR_W-1:0] OFF_RST     = 12'h0E4;

    // error word bit positions
    localparam int unsigned ERR_OVERRUN = 0;
    localparam int unsigned ERR_BADDESC = 1;
    localparam int unsigned ERR_OFF     = 2;
    localparam int unsigned ERR_INRST   = 16;

    typedef struct packed {
        logic              busy;
        logic              start;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] cmd;
    } slot_st_t;

    function automatic logic [ADDR_W-1:0] desc_off(input int unsigned p, input int unsigned q);
        return OFF_DESC + ADDR_W'(16 * p + 8 * q);
    endfunction

    // completion bit position: irregular, decoded by software
    function automatic int unsigned done_bit(input int unsigned p, input int unsigned q);
        int unsigned b;
        case (p)
            0: b = 16; 1: b = 17; 2: b = 18; 3: b = 19; 4: b = 25; default: b = 26;
        endcase
        if (q != 0) b = (p < 4) ? b + 5 : b + 2;
        return b;
    endfunction

    function automatic logic desc_ok(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] c,
                                     input logic q1);
        logic [1:0] op;
        op = c[23:22];
        return (c[13:0] != 14'd0) && (a[7:0] == 8'd0) &&
               ((op == 2'd1) || ((op == 2'd2) && !q1));
    endfunction
endpackage

// File: rtl/dmaq_slot.sv
module dmaq_slot
    import dmaq_pkg::*;
#(
    parameter bit IS_Q1 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              enable,
    input  logic              in_rst,
    input  logic [WORD_W-1:0] desc_addr,
    input  logic [WORD_W-1:0] desc_cmd,
    input  logic              fetch_done,
    output logic              busy,
    output logic              start,
    output logic [WORD_W-1:0] snap_addr,
    output logic [WORD_W-1:0] snap_cmd,
    output logic              done_last,
    output logic              err_overrun,
    output logic              err_bad,
    output logic              err_off,
    output logic              err_rst
);
    slot_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.start  = 1'b0;
        done_last   = 1'b0;
        err_overrun = 1'b0;
        err_bad     = 1'b0;
        err_off     = 1'b0;
        err_rst     = 1'b0;
        if (in_rst) begin
            st_d.busy = 1'b0;
        end else if (fetch_done && st_q.busy) begin
            st_d.busy = 1'b0;
            done_last = st_q.cmd[24];
        end
        if (launch) begin
            if (in_rst)                            err_rst     = 1'b1;
            else if (!enable)                      err_off     = 1'b1;
            else if (st_q.busy)                    err_overrun = 1'b1;
            else if (!desc_ok(desc_addr, desc_cmd, IS_Q1)) err_bad = 1'b1;
            else begin
                st_d.busy  = 1'b1;
                st_d.start = 1'b1;
                st_d.addr  = desc_addr;
                st_d.cmd   = desc_cmd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign start     = st_q.start;
    assign snap_addr = st_q.addr;
    assign snap_cmd  = st_q.cmd;
endmodule

// File: rtl/dmaq_path_reset.sv
module dmaq_path_reset #(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic in_rst
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (req)     cnt_d = CNT_W'(RST_CYCLES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign in_rst = (cnt_q != '0);
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
    import dmaq_pkg::*;
#(
    parameter int unsigned NUM_PATHS  = 6,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr_en,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    input  logic [ADDR_W-1:0]             reg_raddr,
    output logic [WORD_W-1:0]             reg_rdata,
    input  logic [NUM_PATHS-1:0]          flush_i,
    output logic [2*NUM_PATHS-1:0]        fetch_start_o,
    output logic [2*NUM_PATHS*WORD_W-1:0] fetch_addr_o,
    output logic [2*NUM_PATHS*WORD_W-1:0] fetch_cmd_o,
    input  logic [2*NUM_PATHS-1:0]        fetch_done_i,
    output logic [2*NUM_PATHS-1:0]        fetch_busy_o
);
    localparam int unsigned SLOTS = 2 * NUM_PATHS;

    typedef struct packed {
        logic                                    enable;
        logic [WORD_W-1:0]                       status;
        logic [WORD_W-1:0]                       err;
        logic [NUM_PATHS-1:0][1:0][WORD_W-1:0]   dadr;
        logic [NUM_PATHS-1:0][1:0][WORD_W-1:0]   dcmd;
    } regs_t;

    regs_t r_d, r_q;

    logic [SLOTS-1:0]     launch, done_last, e_ovr, e_bad, e_off, e_rst;
    logic [NUM_PATHS-1:0] rst_req, in_rst;
    logic                 enable_w;
    logic [WORD_W-1:0]    status_w;
    logic [2:0]           launch_path;
    logic                 launch_wr;

    assign launch_wr   = reg_wr_en && (reg_addr == OFF_LAUNCH);
    assign launch_path = reg_wdata[10:8];

    always_comb begin
        for (int p = 0; p < NUM_PATHS; p++) begin
            launch[2*p]   = launch_wr && reg_wdata[0] && (launch_path == 3'(p));
            launch[2*p+1] = (launch_wr && reg_wdata[4] && (launch_path == 3'(p))) || flush_i[p];
            rst_req[p]    = reg_wr_en && reg_wdata[0] && (reg_addr == OFF_RST + ADDR_W'(4 * p));
        end
    end

    generate
        for (genvar gp = 0; gp < NUM_PATHS; gp++) begin : g_path
            dmaq_path_reset #(.RST_CYCLES(RST_CYCLES)) u_rst (
                .clk(clk), .rst_n(rst_n), .req(rst_req[gp]), .in_rst(in_rst[gp])
            );
            for (genvar gq = 0; gq < 2; gq++) begin : g_queue
                localparam int unsigned S = 2 * gp + gq;
                dmaq_slot #(.IS_Q1(gq == 1)) u_slot (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .launch     (launch[S]),
                    .enable     (r_q.enable),
                    .in_rst     (in_rst[gp]),
                    .desc_addr  (r_q.dadr[gp][gq]),
                    .desc_cmd   (r_q.dcmd[gp][gq]),
                    .fetch_done (fetch_done_i[S]),
                    .busy       (fetch_busy_o[S]),
                    .start      (fetch_start_o[S]),
                    .snap_addr  (fetch_addr_o[S*WORD_W +: WORD_W]),
                    .snap_cmd   (fetch_cmd_o[S*WORD_W +: WORD_W]),
                    .done_last  (done_last[S]),
                    .err_overrun(e_ovr[S]),
                    .err_bad    (e_bad[S]),
                    .err_off    (e_off[S]),
                    .err_rst    (e_rst[S])
                );
            end
        end
    endgenerate

    always_comb begin
        logic [WORD_W-1:0] st_set, st_clr, er_set, er_clr;
        r_d    = r_q;
        st_set = '0;
        er_set = '0;
        for (int p = 0; p < NUM_PATHS; p++)
            for (int q = 0; q < 2; q++)
                if (done_last[2*p+q]) st_set[done_bit(p, q)] = 1'b1;
        er_set[ERR_OVERRUN] = |e_ovr;
        er_set[ERR_BADDESC] = |e_bad;
        er_set[ERR_OFF]     = |e_off;
        er_set[ERR_INRST]   = |e_rst;
        st_clr = (reg_wr_en && reg_addr == OFF_ST_CLR)  ? reg_wdata : '0;
        er_clr = (reg_wr_en && reg_addr == OFF_ERR_CLR) ? reg_wdata : '0;
        if (reg_wr_en && reg_addr == OFF_ENABLE) r_d.enable = reg_wdata[0];
        for (int p = 0; p < NUM_PATHS; p++)
            for (int q = 0; q < 2; q++) begin
                if (reg_wr_en && reg_addr == desc_off(p, q))         r_d.dadr[p][q] = reg_wdata;
                if (reg_wr_en && reg_addr == desc_off(p, q) + 12'd4) r_d.dcmd[p][q] = reg_wdata;
            end
        r_d.status = (r_q.status & ~st_clr) | st_set;
        r_d.err    = (r_q.err & ~er_clr) | er_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == OFF_ENABLE) reg_rdata[0] = r_q.enable;
        if (reg_raddr == OFF_STATUS) reg_rdata = r_q.status;
        if (reg_raddr == OFF_ERR)    reg_rdata = r_q.err;
        for (int p = 0; p < NUM_PATHS; p++) begin
            for (int q = 0; q < 2; q++) begin
                if (reg_raddr == desc_off(p, q))         reg_rdata = r_q.dadr[p][q];
                if (reg_raddr == desc_off(p, q) + 12'd4) reg_rdata = r_q.dcmd[p][q];
            end
            if (reg_raddr == OFF_RST + ADDR_W'(4 * p)) reg_rdata[0] = in_rst[p];
        end
    end

    assign enable_w = r_q.enable;
    assign status_w = r_q.status;
endmodule

// File: rtl/dmaq_ctrl_chk.sv
module dmaq_ctrl_chk #(
    parameter int unsigned NUM_PATHS = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable_w,
    input logic [31:0]            status_w,
    input logic [NUM_PATHS-1:0]   in_rst,
    input logic [2*NUM_PATHS-1:0] fetch_start_o,
    input logic [2*NUM_PATHS-1:0] fetch_busy_o,
    input logic [2*NUM_PATHS-1:0] fetch_done_i
);
    generate
        for (genvar gp = 0; gp < NUM_PATHS; gp++) begin : g_p
            for (genvar gq = 0; gq < 2; gq++) begin : g_q
                localparam int unsigned S = 2 * gp + gq;
                localparam int unsigned B = dmaq_pkg::done_bit(gp, gq);

                assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    fetch_start_o[S] |-> fetch_busy_o[S]);

                assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    fetch_start_o[S] |-> !$past(fetch_busy_o[S]));

                assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    fetch_start_o[S] |-> $past(enable_w));

                assert_done_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(status_w[B]) |-> $past(fetch_done_i[S]));

                assert_reset_drops_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
                    (in_rst[gp] && $past(in_rst[gp])) |-> !fetch_busy_o[S]);

                assert_reset_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(in_rst[gp]) |-> !fetch_start_o[S]);
            end
        end
    endgenerate
endmodule

bind dmaq_ctrl dmaq_ctrl_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_w     (enable_w),
    .status_w     (status_w),
    .in_rst       (in_rst),
    .fetch_start_o(fetch_start_o),
    .fetch_busy_o (fetch_busy_o),
    .fetch_done_i (fetch_done_i)
);

// File: tb/tb_dmaq_ctrl.sv
module tb_dmaq_ctrl;
    localparam int NP = 6;
    localparam int NS = 2 * NP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [11:0]       reg_raddr = '0;
    logic [31:0]       reg_rdata;
    logic [NP-1:0]     flush_i = '0;
    logic [NS-1:0]     fetch_start_o;
    logic [NS*32-1:0]  fetch_addr_o;
    logic [NS*32-1:0]  fetch_cmd_o;
    logic [NS-1:0]     fetch_done_i = '0;
    logic [NS-1:0]     fetch_busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dmaq_ctrl #(.NUM_PATHS(NP), .RST_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .flush_i(flush_i), .fetch_start_o(fetch_start_o), .fetch_addr_o(fetch_addr_o),
        .fetch_cmd_o(fetch_cmd_o), .fetch_done_i(fetch_done_i), .fetch_busy_o(fetch_busy_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic done_pulse(input int s);
        fetch_done_i[s] = 1'b1;
        @(negedge clk);
        fetch_done_i[s] = 1'b0;
    endtask

    task automatic flush_pulse(input int p);
        flush_i[p] = 1'b1;
        @(negedge clk);
        flush_i[p] = 1'b0;
    endtask

    task automatic launch(input int p, input int q);
        wr(12'h0D4, (q == 0 ? 32'h1 : 32'h10) | (32'(p) << 8));
    endtask

    function automatic int exp_bit(input int p, input int q);
        if (q == 0) return (p < 4) ? 16 + p : 21 + p;
        return (p < 4) ? 21 + p : 23 + p;
    endfunction

    function automatic logic [11:0] dbase(input int p, input int q);
        return 12'(20 + 16 * p + 8 * q);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] a, c;
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h004, v); check(v == 0, "R1 enable", v, 0);
        rd(12'h090, v); check(v == 0, "R1 status", v, 0);
        rd(12'h0A0, v); check(v == 0, "R1 error", v, 0);
        rd(12'h014, v); check(v == 0, "R1 desc", v, 0);
        rd(12'h0E4, v); check(v == 0, "R1 reset reg", v, 0);
        check(fetch_start_o == 0 && fetch_busy_o == 0, "R1 outputs", fetch_busy_o, 0);

        // R8 launch while disabled
        wr(dbase(0, 0), 32'h100); wr(dbase(0, 0) + 4, 32'h0040_0004);
        launch(0, 0);
        check(fetch_start_o[0] == 0, "R8 no start", fetch_start_o[0], 0);
        rd(12'h0A0, v); check(v == 32'h4, "R8 err bit2", v, 4);
        wr(12'h0C0, 32'h4);
        rd(12'h0A0, v); check(v == 0, "R11 err clear", v, 0);
        wr(12'h004, 32'h1);

        // R3 R4 R5 R9 R2 sweep over all paths and queues
        for (int p = 0; p < NP; p++) begin
            for (int q = 0; q < 2; q++) begin
                s = 2 * p + q;
                a = 32'(s + 1) << 8;
                c = (32'h1 << 24) | 32'(3 + s);
                if (q == 0) c = c | (32'h2 << 22) | (32'(p % 4) << 30);
                else        c = c | (32'h1 << 22);
                wr(dbase(p, q), a); wr(dbase(p, q) + 4, c);
                rd(dbase(p, q), v);     check(v == a, "R2 addr readback", v, a);
                rd(dbase(p, q) + 4, v); check(v == c, "R2 cmd readback", v, c);
                if (q == 1 && (p % 2 == 1)) flush_pulse(p);
                else                        launch(p, q);
                check(fetch_start_o == (NS'(1) << s), q == 1 && p % 2 == 1 ? "R9 flush start" : "R3 start pulse",
                      fetch_start_o, NS'(1) << s);
                check(fetch_addr_o[s*32 +: 32] == a, "R3 captured addr", fetch_addr_o[s*32 +: 32], a);
                check(fetch_cmd_o[s*32 +: 32] == c, "R3 captured cmd", fetch_cmd_o[s*32 +: 32], c);
                check(fetch_busy_o == (NS'(1) << s), "R3 busy", fetch_busy_o, NS'(1) << s);
                @(negedge clk);
                check(fetch_start_o == 0, "R3 single pulse", fetch_start_o, 0);
                done_pulse(s);
                check(fetch_busy_o == 0, "R4 idle after done", fetch_busy_o, 0);
                rd(12'h090, v);
                check(v == (32'h1 << exp_bit(p, q)), "R4 status bit", v, 32'h1 << exp_bit(p, q));
                wr(12'h0B0, 32'h1 << exp_bit(p, q));
                rd(12'h090, v); check(v == 0, "R5 status clear", v, 0);
            end
        end

        // R5 partial clear keeps other bits
        launch(0, 0); done_pulse(0);
        launch(1, 0); done_pulse(2);
        wr(12'h0B0, 32'h1 << 16);
        rd(12'h090, v); check(v == (32'h1 << 17), "R5 partial clear", v, 32'h1 << 17);
        wr(12'h0B0, 32'hFFFF_FFFF);

        // R4 non-last submission
        wr(dbase(0, 0) + 4, 32'h0040_0008);
        launch(0, 0); done_pulse(0);
        rd(12'h090, v); check(v == 0, "R4 non-last no status", v, 0);
        check(fetch_busy_o[0] == 0, "R4 non-last idle", fetch_busy_o[0], 0);

        // R6 overrun
        launch(0, 0);
        wr(dbase(0, 0), 32'h0000_0F00);
        launch(0, 0);
        check(fetch_start_o[0] == 0, "R6 no second start", fetch_start_o[0], 0);
        check(fetch_addr_o[31:0] == 32'h100, "R6 capture kept", fetch_addr_o[31:0], 32'h100);
        rd(12'h0A0, v); check(v == 32'h1, "R6 err bit0", v, 1);
        wr(12'h0C0, 32'h1);
        rd(12'h0A0, v); check(v == 0, "R11 err clear", v, 0);
        done_pulse(0);

        // R7 invalid descriptors on path 1
        for (int k = 0; k < 4; k++) begin
            int qq;
            qq = (k == 3) ? 1 : 0;
            case (k)
                0: begin a = 32'h200; c = 32'h0040_0000; end  // zero count
                1: begin a = 32'h280; c = 32'h0040_0004; end  // misaligned
                2: begin a = 32'h200; c = 32'h00C0_0004; end  // op 3
                default: begin a = 32'h200; c = 32'h0080_0004; end  // read on queue 1
            endcase
            wr(dbase(1, qq), a); wr(dbase(1, qq) + 4, c);
            launch(1, qq);
            check(fetch_start_o == 0 && fetch_busy_o == 0, "R7 rejected", fetch_busy_o, 0);
            rd(12'h0A0, v); check(v == 32'h2, "R7 err bit1", v, 2);
            wr(12'h0C0, 32'h2);
        end

        // R10 reset on a path with both queues busy
        wr(dbase(2, 0), 32'h500); wr(dbase(2, 0) + 4, 32'h0040_0004);
        wr(dbase(2, 1), 32'h600); wr(dbase(2, 1) + 4, 32'h0040_0004);
        launch(2, 0); flush_pulse(2);
        check(fetch_busy_o[5:4] == 2'b11, "R10 both busy", fetch_busy_o[5:4], 3);
        wr(12'h0EC, 32'h1);
        rd(12'h0EC, v); check(v == 1, "R10 reset readback", v, 1);
        launch(2, 0);
        check(fetch_busy_o[5:4] == 2'b00, "R10 busy dropped", fetch_busy_o[5:4], 0);
        check(fetch_start_o[4] == 0, "R10 launch rejected", fetch_start_o[4], 0);
        rd(12'h0A0, v); check(v == (32'h1 << 16), "R10 err bit16", v, 32'h1 << 16);
        rd(12'h0EC, v); check(v == 1, "R10 still in reset", v, 1);
        repeat (2) @(negedge clk);
        rd(12'h0EC, v); check(v == 1, "R10 last reset cycle", v, 1);
        @(negedge clk);
        rd(12'h0EC, v); check(v == 0, "R10 reset finished", v, 0);
        launch(2, 0);
        check(fetch_start_o[4] == 1, "R10 launch after reset", fetch_start_o[4], 1);
        done_pulse(4);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule